// File: doc/BRIEF.md
# Snapshot Statistics Counter Bank

This block keeps one live event counter for each statistic a MAC produces. Each counter advances by one in every cycle that its event strobe is high. Software never reads the live counters. Instead, it writes a snap command that copies every live counter into a shadow set in a single clock edge. It then reads the shadow set at leisure through a narrow 16-bit register port and gets a coherent picture of all the counters. A clear command zeroes the counters, the shadow set and the rollover state together.

A counter that passes its maximum value wraps to zero and sets a sticky rollover flag of its own. The flags are packed into four 16-bit rollover registers, and reading a register clears it. Software adds one wrap to a count for each flag it collects, which lets it extend the count beyond the hardware width. Four mask registers select which flags drive the interrupt output. All masks are zero after reset, so software can poll without taking interrupts.

Register map (word addresses):

| Address | Contents |
|---|---|
| 0x000 | Control register |
| 0x004 + j | Rollover register j |
| 0x008 + j | Mask register j |
| 0x100 + 4·k + w | Word w of shadow counter k |

The counter width is `CNT_W`, 40 bits by default and at most 40. The number of counters is `NUM_CNT`, at most 64.

Top module: `stat_snap_bank`

## Requirements
- R1: After reset, every shadow word, every rollover register and every mask register reads 0, and `irq_o` is low.
- R2: A live counter increases by exactly one for each clock cycle in which its bit of `ev_i` is high. Several counters can advance in the same cycle.
- R3: Counter k occupies addresses 0x100+4k to 0x100+4k+3. Word 0 holds bits 15:0. Word 1 holds bits 31:16. Word 2 holds bits 39:32 in its bits 7:0, and its bits 15:8 read 0. Word 3 reads 0.
- R4: Writing bit 0 (snap) to the control register at address 0 copies every live counter into its shadow at the same edge. A shadow keeps its value until the next snap or clear, however its live counter moves.
- R5: Writing bit 1 (clear) to the control register zeroes all live counters, shadows and rollover flags. An event in the same cycle as a clear is lost.
- R6: A counter that increments from its all-ones value wraps to 0 and sets its rollover flag. The flag for counter k is bit k mod 16 of rollover register k/16, at address 0x004 + k/16.
- R7: Reading a rollover register returns its flags and clears them. A wrap that lands in the same cycle as the read leaves its flag set afterwards.
- R8: `irq_o` is high while any rollover flag is set whose bit is also set in the matching mask register at 0x008+j. The mask registers can be read back, and they reset to 0.
- R9: When a snap and an event fall in the same cycle, the shadow receives the value from before that event, and the live counter keeps the event.
- R10: `rdata_o` is registered. It shows the addressed word one cycle after `rd_i` and holds that value while `rd_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ev_i | input | NUM_CNT | Event strobes, one per counter |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Register word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| irq_o | output | 1 | Masked rollover interrupt |

## Verification
Three pairs of functions can land in the same cycle, and each pair is provoked on purpose:
- **Wrap and rollover-register read.** A narrowed instance is brought to one count below its wrap. A read of the rollover register then goes out in the same cycle as the final event. The check passes if the read returns the old flags and the new flag shows up on the following read.
- **Clear and event.** An event is driven in the same cycle as a clear. A later snap must read zero.
- **Snap and event.** An event is driven in the same cycle as a snap. The shadow must show the count from before the event, and the next snap must show the event included.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int WORD_W      = 16;
  localparam int ROLL_REGS   = 4;
  localparam int MAX_CNT_W   = 40;
  localparam int FLAG_SLOTS  = ROLL_REGS * WORD_W;
  localparam int CTRL_SNAP   = 0;
  localparam int CTRL_CLEAR  = 1;
  localparam logic [1:0] SEL_ROLL = 2'b01;
  localparam logic [1:0] SEL_MASK = 2'b10;
endpackage

// File: rtl/stat_cnt_lane.sv
module stat_cnt_lane #(
  parameter int CNT_W = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ev_i,
  input  logic             snap_i,
  input  logic             clr_i,
  input  logic             rd_clr_i,
  output logic [CNT_W-1:0] shadow_o,
  output logic             flag_o
);
  logic [CNT_W-1:0] live_q, live_d, shadow_q, shadow_d;
  logic             flag_q, flag_d;
  logic             at_max, wrap, live_en, shadow_en, flag_en;

  always_comb begin
    at_max    = &live_q;
    wrap      = !clr_i && ev_i && at_max;
    live_en   = clr_i || ev_i;
    live_d    = clr_i ? '0 : live_q + CNT_W'(1);
    shadow_en = clr_i || snap_i;
    shadow_d  = clr_i ? '0 : live_q;
    flag_en   = clr_i || wrap || rd_clr_i;
    flag_d    = clr_i ? 1'b0 : (wrap || (flag_q && !rd_clr_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q   <= '0;
      shadow_q <= '0;
      flag_q   <= 1'b0;
    end else begin
      if (live_en)   live_q   <= live_d;
      if (shadow_en) shadow_q <= shadow_d;
      if (flag_en)   flag_q   <= flag_d;
    end
  end

  assign shadow_o = shadow_q;
  assign flag_o   = flag_q;

  AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (live_q == '0 && shadow_q == '0 && !flag_q)); // R5
  AST_ONE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i && !clr_i) |=> (live_q == $past(live_q) + CNT_W'(1))); // R2
  AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!snap_i && !clr_i) |=> $stable(shadow_q)); // R4
  AST_SNAP_PRE_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snap_i && !clr_i) |=> (shadow_q == $past(live_q))); // R9
  AST_WRAP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i && !clr_i && (&live_q)) |=> (flag_q && live_q == '0)); // R6
  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && !clr_i && !(ev_i && (&live_q))) |=> !flag_q); // R7
endmodule

// File: rtl/stat_host_if.sv
module stat_host_if
  import stat_pkg::*;
#(
  parameter int NUM_CNT = 8,
  parameter int CNT_W   = 40,
  parameter int ADDR_W  = 10
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_i,
  input  logic                            rd_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [WORD_W-1:0]               wdata_i,
  input  logic [NUM_CNT-1:0][CNT_W-1:0]   shadow_i,
  input  logic [NUM_CNT-1:0]              flags_i,
  output logic                            snap_o,
  output logic                            clr_o,
  output logic [NUM_CNT-1:0]              rd_clr_o,
  output logic [WORD_W-1:0]               rdata_o,
  output logic                            irq_o
);
  localparam int HI_W = ADDR_W - 8;

  logic                                  lo_region, cnt_region;
  logic                                  ctrl_hit, roll_hit, mask_hit;
  logic [1:0]                            reg_idx;
  logic [5:0]                            cnt_idx;
  logic [ROLL_REGS-1:0][WORD_W-1:0]      mask_q, mask_d;
  logic                                  mask_en;
  logic [FLAG_SLOTS-1:0]                 flag_pad;
  logic [CNT_W-1:0]                      cnt_sel;
  logic [MAX_CNT_W-1:0]                  cnt_wide;
  logic [WORD_W-1:0]                     rdata_q, rdata_d;

  always_comb begin
    lo_region  = (addr_i[ADDR_W-1:4] == '0);
    cnt_region = (addr_i[ADDR_W-1:8] == HI_W'(1));
    ctrl_hit   = lo_region && (addr_i[3:0] == 4'h0);
    roll_hit   = lo_region && (addr_i[3:2] == SEL_ROLL);
    mask_hit   = lo_region && (addr_i[3:2] == SEL_MASK);
    reg_idx    = addr_i[1:0];
    cnt_idx    = addr_i[7:2];
    snap_o     = wr_i && ctrl_hit && wdata_i[CTRL_SNAP];
    clr_o      = wr_i && ctrl_hit && wdata_i[CTRL_CLEAR];
    flag_pad   = FLAG_SLOTS'(flags_i);
    irq_o      = |(flag_pad & mask_q);
  end

  always_comb begin
    for (int i = 0; i < NUM_CNT; i++) begin
      rd_clr_o[i] = rd_i && roll_hit && (int'(reg_idx) == i / WORD_W);
    end
  end

  always_comb begin
    mask_en = wr_i && mask_hit;
    mask_d  = mask_q;
    for (int j = 0; j < ROLL_REGS; j++) begin
      if (int'(reg_idx) == j) mask_d[j] = wdata_i;
    end
  end

  always_comb begin
    cnt_sel = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (int'(cnt_idx) == i) cnt_sel = shadow_i[i];
    end
    cnt_wide = MAX_CNT_W'(cnt_sel);
    rdata_d  = '0;
    if (roll_hit) begin
      for (int j = 0; j < ROLL_REGS; j++) begin
        if (int'(reg_idx) == j) rdata_d = flag_pad[j*WORD_W +: WORD_W];
      end
    end else if (mask_hit) begin
      for (int j = 0; j < ROLL_REGS; j++) begin
        if (int'(reg_idx) == j) rdata_d = mask_q[j];
      end
    end else if (cnt_region) begin
      case (reg_idx)
        2'd0:    rdata_d = cnt_wide[15:0];
        2'd1:    rdata_d = cnt_wide[31:16];
        2'd2:    rdata_d = {8'h00, cnt_wide[39:32]};
        default: rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (mask_en) mask_q  <= mask_d;
      if (rd_i)    rdata_q <= rdata_d;
    end
  end

  assign rdata_o = rdata_q;

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o)); // R10
  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(mask_q)); // R8
endmodule

// File: rtl/stat_snap_bank.sv
module stat_snap_bank
  import stat_pkg::*;
#(
  parameter int NUM_CNT = 8,
  parameter int CNT_W   = 40,
  parameter int ADDR_W  = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_CNT-1:0] ev_i,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [15:0]        wdata_i,
  output logic [15:0]        rdata_o,
  output logic               irq_o
);
  logic                          snap, clr;
  logic [NUM_CNT-1:0]            rd_clr, flags;
  logic [NUM_CNT-1:0][CNT_W-1:0] shadow;

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_lane
    stat_cnt_lane #(.CNT_W(CNT_W)) u_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ev_i     (ev_i[g]),
      .snap_i   (snap),
      .clr_i    (clr),
      .rd_clr_i (rd_clr[g]),
      .shadow_o (shadow[g]),
      .flag_o   (flags[g])
    );
  end

  stat_host_if #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_host (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_i),
    .rd_i     (rd_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .shadow_i (shadow),
    .flags_i  (flags),
    .snap_o   (snap),
    .clr_o    (clr),
    .rd_clr_o (rd_clr),
    .rdata_o  (rdata_o),
    .irq_o    (irq_o)
  );

  AST_ONE_CMD_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snap || clr) |-> wr_i); // R4
endmodule

// File: tb/stat_snap_bank_tb_top.sv
module stat_snap_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [9:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [19:0] ev = '0;
  logic [15:0] rdata_w, rdata_n, got;
  logic        irq_w, irq_n;
  int          n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  stat_snap_bank #(.NUM_CNT(8), .CNT_W(40), .ADDR_W(10)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ev_i(sel ? 8'h00 : ev[7:0]),
    .wr_i(wr && !sel), .rd_i(rd && !sel), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata_w), .irq_o(irq_w));

  stat_snap_bank #(.NUM_CNT(20), .CNT_W(10), .ADDR_W(10)) dut_n (
    .clk_i(clk), .rst_ni(rst_n), .ev_i(sel ? ev : 20'h0),
    .wr_i(wr && sel), .rd_i(rd && sel), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata_n), .irq_o(irq_n));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic r, input logic [9:0] a,
                     input logic [15:0] d, input logic [19:0] e);
    @(negedge clk);
    wr = w; rd = r; addr = a; wdata = d; ev = e;
    @(negedge clk);
    wr = 1'b0; rd = 1'b0; ev = '0;
    got = sel ? rdata_n : rdata_w;
  endtask

  task automatic rd_reg(input logic [9:0] a);
    bus(1'b0, 1'b1, a, 16'h0, '0);
  endtask

  task automatic events(input logic [19:0] m, input int n);
    @(negedge clk);
    ev = m;
    repeat (n) @(negedge clk);
    ev = '0;
  endtask

  task automatic snap();
    bus(1'b1, 1'b0, 10'h000, 16'h0001, '0);
  endtask

  task automatic t_reset();
    sel = 1'b0;
    rd_reg(10'h100); check("R1 shadow word", got, 16'h0);
    rd_reg(10'h004); check("R1 rollover reg", got, 16'h0);
    rd_reg(10'h008); check("R1 mask reg", got, 16'h0);
    check("R1 irq", {15'h0, irq_w}, 16'h0);
  endtask

  task automatic t_count_and_hold();
    events(20'h00005, 3);
    events(20'h00001, 2);
    rd_reg(10'h100); check("R4 shadow holds before snap", got, 16'h0);
    snap();
    rd_reg(10'h100); check("R2 counter0", got, 16'd5);
    rd_reg(10'h108); check("R2 counter2", got, 16'd3);
    rd_reg(10'h104); check("R2 counter1 idle", got, 16'd0);
    events(20'h00001, 2);
    rd_reg(10'h100); check("R4 shadow unchanged by events", got, 16'd5);
    rd_reg(10'h100); check("R10 rdata stable on repeat", got, 16'd5);
    snap();
    rd_reg(10'h100); check("R4 second snap", got, 16'd7);
  endtask

  task automatic t_snap_event();
    bus(1'b1, 1'b0, 10'h000, 16'h0001, 20'h00002);
    rd_reg(10'h104); check("R9 snap takes pre-event value", got, 16'd0);
    snap();
    rd_reg(10'h104); check("R9 event kept in live counter", got, 16'd1);
  endtask

  task automatic t_clear_event();
    bus(1'b1, 1'b0, 10'h000, 16'h0002, 20'h00001);
    rd_reg(10'h108); check("R5 clear zeroes shadow", got, 16'd0);
    snap();
    rd_reg(10'h100); check("R5 clear beats event", got, 16'd0);
    rd_reg(10'h104); check("R5 counter1 cleared", got, 16'd0);
  endtask

  task automatic t_wide_words();
    events(20'h00010, 65540);
    snap();
    rd_reg(10'h110); check("R3 word0 bits 15:0", got, 16'd4);
    rd_reg(10'h111); check("R3 word1 bits 31:16", got, 16'd1);
    rd_reg(10'h112); check("R3 word2 bits 39:32", got, 16'd0);
    rd_reg(10'h113); check("R3 word3 zero", got, 16'd0);
  endtask

  task automatic t_rollover();
    sel = 1'b1;
    events(20'h20008, 1024);
    check("R8 masked off no irq", {15'h0, irq_n}, 16'h0);
    bus(1'b1, 1'b0, 10'h009, 16'h0002, '0);
    check("R8 irq with mask", {15'h0, irq_n}, 16'h1);
    rd_reg(10'h009); check("R8 mask readback", got, 16'h0002);
    rd_reg(10'h005); check("R6 counter17 flag reg1 bit1", got, 16'h0002);
    check("R8 irq drops after read", {15'h0, irq_n}, 16'h0);
    rd_reg(10'h005); check("R7 reg1 cleared by read", got, 16'h0);
    rd_reg(10'h004); check("R6 counter3 flag reg0 bit3", got, 16'h0008);
    rd_reg(10'h004); check("R7 reg0 cleared by read", got, 16'h0);
    snap();
    rd_reg(10'h10C); check("R6 counter3 wrapped to 0", got, 16'h0);
  endtask

  task automatic t_read_wrap_collide();
    events(20'h00008, 1023);
    bus(1'b0, 1'b1, 10'h004, 16'h0, 20'h00008);
    check("R7 read in wrap cycle returns old", got, 16'h0);
    rd_reg(10'h004); check("R7 wrap survives same-cycle read", got, 16'h0008);
    rd_reg(10'h004); check("R7 cleared afterwards", got, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_count_and_hold();
    t_snap_event();
    t_clear_event();
    t_wide_words();
    t_rollover();
    t_read_wrap_collide();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule